// File: doc/BRIEF.md
# UART Prioritized Interrupt Identification

This block is the interrupt status logic of a 16550-style serial port. Five event inputs arrive from the rest of the UART: a receive line error, receive data ready, receive timeout, transmit holding register empty and a modem status change. Each event has its own enable bit. An enabled event sets a pending flag for its source. The block then presents a status byte naming one pending source, so that the host can jump straight to the matching service routine. An active-high interrupt line tells the host that at least one flag is pending.

Once a source has been reported, its code stays on the status byte until that source is serviced. A read strobe on the status register clears only the source currently shown. On the next clock the byte moves to the highest-priority source still pending, so a chain of reads walks through every pending source in priority order. The upper bits of the byte show the FIFO-enable state and the 64-byte depth mode.

Top module: `uart_irq_ident`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), status bits [3:0] read 0001 and irq is 0.
- R2: While a source is reported, status bits [3:0] carry its code: line error 0110, receive data ready 0100, receive timeout 1100, transmit holding empty 0010, modem change 0000. The code appears in the first clock after the event is sampled.
- R3: When the block chooses a new source, it picks the highest priority pending one. The order from highest to lowest is line error, receive data ready, receive timeout, transmit holding empty, modem change.
- R4: A status read clears only the reported source. One clock after the read strobe, the byte reports the next highest pending source, or 0001 if no source is left.
- R5: While a source is reported, a newly pending source of any priority leaves the code unchanged until the reported source is cleared.
- R6: An event whose enable bit is 0 sets no pending flag. irq stays 0 and the byte stays 0001.
- R7: Clearing a source's enable bit clears its pending flag on the next clock. If that source was being reported, the byte moves to the next pending source.
- R8: If an event arrives in the same cycle that a read clears the same source, the flag stays set and the code stays on the byte.
- R9: Status bits [7:6] both equal fifo_en, bit 5 equals fifo_deep (1 = 64-byte mode, 0 = 16-byte mode) and bit 4 is always 0. These bits follow their inputs in the same cycle.
- R10: irq is 1 exactly when some enabled source is pending, and status bit 0 is always the inverse of irq.
- R11: The byte seen while the read strobe is high is the code being cleared. The clear takes effect only at the closing clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt | input | 5 | Event pulses. Bit 0 line error, 1 receive ready, 2 receive timeout, 3 transmit empty, 4 modem change |
| src_en | input | 5 | Per-source enable, same bit order as src_evt |
| status_rd | input | 1 | Read strobe on the status register, one cycle per read |
| fifo_en | input | 1 | FIFOs enabled |
| fifo_deep | input | 1 | 64-byte FIFO mode selected |
| status | output | 8 | Encoded interrupt status byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
Event, enable and read effects are registered once. A change driven before edge k is therefore visible on status and irq just after edge k. The bench drives each vector at a falling edge and compares one nanosecond after the following rising edge. The FIFO mode bits have no register in their path, so they are compared in that same window without an extra clock. The read-data check is the exception: it samples the byte while the strobe is still high, before the clearing edge, and samples again after the edge.

// File: rtl/uart_irq_pkg.sv
// Package: shared constants and helpers for the UART interrupt identification block.
// Assumes source index 0 has the highest priority and index NSRC-1 the lowest.
package uart_irq_pkg;

    localparam int NSRC  = 5;
    localparam int IDX_W = $clog2(NSRC);

    // Source indices, ordered by priority (lower index wins).
    localparam int SRC_LINE  = 0;
    localparam int SRC_RXRDY = 1;
    localparam int SRC_RXTMO = 2;
    localparam int SRC_THRE  = 3;
    localparam int SRC_MODEM = 4;

    typedef logic [NSRC-1:0]  src_vec_t;
    typedef logic [IDX_W-1:0] src_idx_t;

    // Four-bit identification code for a source index.
    function automatic logic [3:0] src_code(input src_idx_t idx);
        logic [3:0] c;
        case (idx)
            src_idx_t'(SRC_LINE):  c = 4'b0110;
            src_idx_t'(SRC_RXRDY): c = 4'b0100;
            src_idx_t'(SRC_RXTMO): c = 4'b1100;
            src_idx_t'(SRC_THRE):  c = 4'b0010;
            default:               c = 4'b0000;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/uart_irq_pend_bank.sv
// Module: one pending flag per interrupt source.
// A flag sets on an enabled event and clears on a targeted clear or when its
// enable drops. An event wins over a clear in the same cycle.
// Assumes clr is one-hot or zero.
module uart_irq_pend_bank
    import uart_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t evt,
    input  src_vec_t en,
    input  src_vec_t clr,
    output src_vec_t pend_d,
    output src_vec_t pend_q
);

    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        // Next value of flag i: set by an event, held unless cleared, masked by enable.
        assign pend_d[i] = en[i] & (evt[i] | (pend_q[i] & ~clr[i]));

        // Register flag i.
        always_ff @(posedge clk) begin
            if (!rst_n) pend_q[i] <= 1'b0;
            else        pend_q[i] <= pend_d[i];
        end
    end

endmodule

// File: rtl/uart_irq_arbiter.sv
// Module: selects the reported source and holds it until it is serviced.
// A reported source stays selected while its next-state flag is set. Otherwise
// the highest-priority next-state flag is taken, so a read moves the report on
// within one clock.
module uart_irq_arbiter
    import uart_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t pend_d,
    output logic     cur_valid,
    output src_idx_t cur_idx
);

    src_idx_t pick_idx;
    logic     hold;

    // Priority pick: scan from lowest to highest priority so that the last hit wins.
    always_comb begin
        pick_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend_d[i]) pick_idx = src_idx_t'(i);
        end
    end

    // Lock: keep the current report while its source is still pending.
    assign hold = cur_valid && pend_d[cur_idx];

    // Register the reported source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_valid <= 1'b0;
            cur_idx   <= '0;
        end else begin
            cur_valid <= |pend_d;
            if (!hold) cur_idx <= pick_idx;
        end
    end

endmodule

// File: rtl/uart_irq_status_fmt.sv
// Module: formats the status byte from the reported source and the FIFO mode inputs.
// Purely combinational. Bit 0 is low while a source is reported.
module uart_irq_status_fmt
    import uart_irq_pkg::*;
(
    input  logic       cur_valid,
    input  src_idx_t   cur_idx,
    input  logic       fifo_en,
    input  logic       fifo_deep,
    output logic [7:0] status
);

    logic [3:0] code;

    // Build the low nibble: the source code, or the idle value.
    always_comb begin
        if (cur_valid) code = src_code(cur_idx);
        else           code = 4'b0001;
    end

    // Assemble the full byte.
    assign status = {fifo_en, fifo_en, fifo_deep, 1'b0, code};

endmodule

// File: rtl/uart_irq_ident.sv
// Module: top of the UART interrupt identification block.
// Combines the pending flags, the locking arbiter and the status formatter.
// A read clears the source that is on the status byte at the strobe.
// Assumes status_rd lasts one cycle per host read.
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] src_evt,
    input  logic [4:0] src_en,
    input  logic       status_rd,
    input  logic       fifo_en,
    input  logic       fifo_deep,
    output logic [7:0] status,
    output logic       irq
);

    src_vec_t pend_d, pend_q, clr;
    logic     cur_valid;
    src_idx_t cur_idx;

    // Clear mask: only the reported source, only on a read.
    always_comb begin
        clr = '0;
        if (status_rd && cur_valid) clr[cur_idx] = 1'b1;
    end

    uart_irq_pend_bank u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (src_evt),
        .en     (src_en),
        .clr    (clr),
        .pend_d (pend_d),
        .pend_q (pend_q)
    );

    uart_irq_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_d    (pend_d),
        .cur_valid (cur_valid),
        .cur_idx   (cur_idx)
    );

    uart_irq_status_fmt u_fmt (
        .cur_valid (cur_valid),
        .cur_idx   (cur_idx),
        .fifo_en   (fifo_en),
        .fifo_deep (fifo_deep),
        .status    (status)
    );

    // Interrupt line: any pending flag (flags exist only while enabled).
    assign irq = |pend_q;

endmodule

// File: rtl/uart_irq_ident_chk.sv
// Checker: port-level properties of uart_irq_ident. Attached by bind below.
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] src_evt,
    input logic [4:0] src_en,
    input logic       status_rd,
    input logic [7:0] status,
    input logic       irq
);

    // R1: reset leaves the block idle.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (status[0] && !irq));

    // R4: a read with no new events moves the report off the read source.
    assert_read_advances_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !status[0] && src_evt == 5'b0 && src_en == 5'h1F)
        |=> (status[3:0] != $past(status[3:0]) || status[0]));

    // R5: without a read or an enable drop, the reported code is locked.
    assert_code_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[0] && !status_rd && src_en == 5'h1F)
        |=> (!status[0] && status[3:0] == $past(status[3:0])));

    // R6: disabled events cannot raise an idle interrupt.
    assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && (src_evt & src_en) == 5'b0) |=> !irq);

    // R8: an enabled event always leaves an interrupt pending.
    assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_evt & src_en) != 5'b0) |=> irq);

    // R9: fixed and mirrored mode bits.
    assert_mode_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[4] && status[7] == status[6]));

    // R10: the irq line agrees with the active-low pending bit.
    assert_irq_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq == !status[0]));

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_evt   (src_evt),
    .src_en    (src_en),
    .status_rd (status_rd),
    .status    (status),
    .irq       (irq)
);

// File: tb/uart_irq_ident_tb_top.sv
// Bench: a vector table walked by one loop, then directed reset and read-timing tests.
module uart_irq_ident_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] src_evt = '0;
    logic [4:0] src_en = '0;
    logic       status_rd = 1'b0;
    logic       fifo_en = 1'b0;
    logic       fifo_deep = 1'b0;
    logic [7:0] status;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    uart_irq_ident dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_evt   (src_evt),
        .src_en    (src_en),
        .status_rd (status_rd),
        .fifo_en   (fifo_en),
        .fifo_deep (fifo_deep),
        .status    (status),
        .irq       (irq)
    );

    // Vector: {evt[5], en[5], rd, fifo_en, fifo_deep, exp_status[8], exp_irq, req[4]}
    localparam int NV = 30;
    localparam logic [25:0] VEC [NV] = '{
        {5'b00000, 5'h1F, 3'b010, 8'hC1, 1'b0, 4'd1},  // R1 idle
        {5'b10000, 5'h1F, 3'b010, 8'hC0, 1'b1, 4'd2},  // R2 modem 0000
        {5'b00000, 5'h1F, 3'b110, 8'hC1, 1'b0, 4'd4},  // R4 read clears
        {5'b01000, 5'h1F, 3'b010, 8'hC2, 1'b1, 4'd2},  // R2 thre 0010
        {5'b00001, 5'h1F, 3'b010, 8'hC2, 1'b1, 4'd5},  // R5 locked
        {5'b00000, 5'h1F, 3'b110, 8'hC6, 1'b1, 4'd4},  // R4 line 0110 next
        {5'b00000, 5'h1F, 3'b110, 8'hC1, 1'b0, 4'd4},  // R4
        {5'b00110, 5'h1F, 3'b010, 8'hC4, 1'b1, 4'd3},  // R3 rxrdy over timeout
        {5'b00000, 5'h1F, 3'b110, 8'hCC, 1'b1, 4'd2},  // R2 timeout 1100
        {5'b00000, 5'h1F, 3'b110, 8'hC1, 1'b0, 4'd4},  // R4
        {5'b11111, 5'h1F, 3'b010, 8'hC6, 1'b1, 4'd3},  // R3 all at once
        {5'b00000, 5'h1F, 3'b110, 8'hC4, 1'b1, 4'd3},  // R3
        {5'b00000, 5'h1F, 3'b110, 8'hCC, 1'b1, 4'd3},  // R3
        {5'b00000, 5'h1F, 3'b110, 8'hC2, 1'b1, 4'd3},  // R3
        {5'b00000, 5'h1F, 3'b110, 8'hC0, 1'b1, 4'd3},  // R3
        {5'b00000, 5'h1F, 3'b110, 8'hC1, 1'b0, 4'd4},  // R4 empty
        {5'b11111, 5'h00, 3'b010, 8'hC1, 1'b0, 4'd6},  // R6 masked
        {5'b00000, 5'h1F, 3'b010, 8'hC1, 1'b0, 4'd6},  // R6 nothing latent
        {5'b01000, 5'h1F, 3'b010, 8'hC2, 1'b1, 4'd10}, // R10
        {5'b00000, 5'h17, 3'b010, 8'hC1, 1'b0, 4'd7},  // R7 enable drop
        {5'b01000, 5'h1F, 3'b010, 8'hC2, 1'b1, 4'd10}, // R10
        {5'b01000, 5'h1F, 3'b110, 8'hC2, 1'b1, 4'd8},  // R8 event beats clear
        {5'b00000, 5'h1F, 3'b110, 8'hC1, 1'b0, 4'd8},  // R8
        {5'b00000, 5'h1F, 3'b000, 8'h01, 1'b0, 4'd9},  // R9 fifos off
        {5'b00000, 5'h1F, 3'b011, 8'hE1, 1'b0, 4'd9},  // R9 64-byte mode
        {5'b00000, 5'h1F, 3'b001, 8'h21, 1'b0, 4'd9},  // R9
        {5'b01000, 5'h1F, 3'b010, 8'hC2, 1'b1, 4'd7},  // R7
        {5'b00001, 5'h1F, 3'b010, 8'hC2, 1'b1, 4'd5},  // R5 locked
        {5'b00000, 5'h17, 3'b010, 8'hC6, 1'b1, 4'd7},  // R7 moves to line
        {5'b00000, 5'h17, 3'b110, 8'hC1, 1'b0, 4'd4}   // R4
    };

    task automatic check(input string req, input logic [7:0] exp_s, input logic exp_i);
        n_cmp++;
        if (status !== exp_s || irq !== exp_i) begin
            n_bad++;
            $display("FAIL %s: status=%02h irq=%0b expected status=%02h irq=%0b",
                     req, status, irq, exp_s, exp_i);
        end
    endtask

    task automatic step(input logic [25:0] v);
        @(negedge clk);
        src_evt   = v[25:21];
        src_en    = v[20:16];
        status_rd = v[15];
        fifo_en   = v[14];
        fifo_deep = v[13];
        @(posedge clk);
        #1;
    endtask

    initial begin
        // R1: reset state.
        src_en = 5'h1F;
        repeat (3) @(posedge clk);
        #1;
        check("R1", 8'h01, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk.
        for (int k = 0; k < NV; k++) begin
            step(VEC[k]);
            check($sformatf("R%0d row %0d", VEC[k][3:0], k), VEC[k][12:5], VEC[k][4]);
        end

        // R11: the byte seen during the strobe is the one being cleared.
        step({5'b00001, 5'h1F, 3'b010, 8'h00, 1'b0, 4'd0});
        @(negedge clk);
        src_evt   = '0;
        status_rd = 1'b1;
        #1;
        check("R11 during strobe", 8'hC6, 1'b1);
        @(posedge clk);
        #1;
        check("R11 after edge", 8'hC1, 1'b0);

        // R1: reset in the middle of pending work.
        step({5'b11111, 5'h1F, 3'b010, 8'h00, 1'b0, 4'd0});
        @(negedge clk);
        src_evt = '0;
        rst_n   = 1'b0;
        @(posedge clk);
        #1;
        check("R1 mid-run reset", 8'hC1, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 no residue", 8'hC1, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        #1000000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule